// File: doc/BRIEF.md
# Bank-Interleaved SDRAM Command Scheduler

This block sits between a client that issues single-word read and write requests and a single-data-rate synchronous DRAM with four internal banks. Accepted requests wait in a small queue. Each cycle the scheduler chooses at most one command for the memory's command bus: row activate, column read, column write, bank precharge or auto-refresh.

The block keeps an open-row register and a countdown timer for each bank. It can therefore tell whether an access hits the open row or misses it. While one bank waits out its row-open delay, the block can work on another bank, which hides much of that delay.

Read data comes back from the memory a fixed number of cycles after the read command. The block pairs that data with the tag of the request that caused it and raises a valid strobe. A refresh timer requests a refresh at a fixed period. While a refresh is pending, new row opens are held back, all open banks are closed, and then the refresh command is sent.

Top module: `sdr_sched`

## Requirements
- R1: While reset is asserted, `mem_cmd_o` is 0 (no operation), `rsp_valid_o` is low and `req_ready_o` is high.
- R2: Command codes on `mem_cmd_o` are 0 no-op, 1 activate, 2 read, 3 write, 4 precharge and 5 refresh. No other code appears. An activate goes only to a closed bank. A read or write goes only to an open bank. A refresh is sent only when every bank is closed.
- R3: A read or write to a bank comes at least `T_RCD` cycles after the activate that opened that bank.
- R4: An activate to a bank comes at least `T_RP` cycles after that bank's last precharge, and at least `T_RFC` cycles after the last refresh.
- R5: An access to the open row of its bank is sent as a column command with no new activate. An access to a bank holding a different row gets a precharge, then an activate, then the column command. The request address is {bank[1:0], row[11:0], column} with the column in the low `COL_W` bits. `mem_addr_o` carries the row on an activate and the column, zero-extended, on a read or write. `mem_bank_o` carries the bank.
- R6: Requests to the same bank take effect in arrival order, so a read that follows a write to the same address returns the written word.
- R7: Requests to different banks overlap. An activate to a second bank may be sent while the first bank is still inside its row-open delay.
- R8: Each read returns exactly one response. `rsp_valid_o` is high exactly `CAS_LAT` cycles after the read command appears on `mem_cmd_o`. In that cycle `rsp_tag_o` equals the request tag and `rsp_data_o` carries the word stored at the read address.
- R9: A refresh is sent once per `REF_PERIOD` cycles, delayed at most by the work needed to close the banks. No activate is sent while a refresh is pending.
- R10: `req_ready_o` is low while the queue holds `QDEPTH` requests. A request that is held back is not lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Queue can accept a request |
| req_we_i | input | 1 | 1 for write, 0 for read |
| req_addr_i | input | BANK_W+ROW_W+COL_W | {bank, row, column} word address |
| req_wdata_i | input | DATA_W | Write word |
| req_tag_i | input | TAG_W | Tag returned with read data |
| mem_cmd_o | output | 3 | Memory command code |
| mem_bank_o | output | BANK_W | Bank of the command |
| mem_addr_o | output | ROW_W | Row or column address |
| mem_wdata_o | output | DATA_W | Write word sent with a write command |
| mem_rdata_i | input | DATA_W | Read word from the memory |
| rsp_valid_o | output | 1 | Read response strobe |
| rsp_tag_o | output | TAG_W | Tag of the returned read |
| rsp_data_o | output | DATA_W | Returned read word |

## Verification
The bench builds the scheduler with `CAS_LAT` = 3, `REF_PERIOD` = 300, `COL_W` = 4 and `QDEPTH` = 4. The short refresh period lets several refreshes land in the middle of traffic, so the hold on activates and the precharge-all sequence are both exercised. A latency of three exercises a read-return pipeline with more than one stage. The four-entry queue fills quickly under back-to-back misses to one bank. The row-open delay stays at ten cycles, which is long enough for an activate to a second bank to fall inside it.

// File: rtl/sdr_sched_pkg.sv
package sdr_sched_pkg;

  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4,
    CMD_REF = 3'd5
  } sdr_cmd_e;

endpackage

// File: rtl/sdr_bank_track.sv
module sdr_bank_track #(
  parameter int ROW_W = 12,
  parameter int T_RCD = 10,
  parameter int T_RP  = 3,
  parameter int T_RFC = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             act_i,
  input  logic             pre_i,
  input  logic             col_i,
  input  logic             ref_i,
  input  logic [ROW_W-1:0] row_i,
  output logic             open_o,
  output logic [ROW_W-1:0] row_o,
  output logic             ready_o
);

  localparam int T_MAX0 = (T_RCD > T_RP) ? T_RCD : T_RP;
  localparam int T_MAX  = (T_MAX0 > T_RFC) ? T_MAX0 : T_RFC;
  localparam int TW     = $clog2(T_MAX + 1);

  logic             open_q, open_d;
  logic [ROW_W-1:0] row_q;
  logic [TW-1:0]    tmr_q, tmr_d;

  always_comb begin
    open_d = open_q;
    tmr_d  = (tmr_q != '0) ? tmr_q - TW'(1) : '0;
    if (act_i) begin
      open_d = 1'b1;
      tmr_d  = TW'(T_RCD - 1);
    end else if (pre_i) begin
      open_d = 1'b0;
      tmr_d  = TW'(T_RP - 1);
    end else if (ref_i) begin
      tmr_d  = TW'(T_RFC - 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      tmr_q  <= '0;
    end else begin
      open_q <= open_d;
      tmr_q  <= tmr_d;
    end
  end

  always_ff @(posedge clk) begin
    if (act_i) row_q <= row_i;
  end

  assign open_o  = open_q;
  assign row_o   = row_q;
  assign ready_o = (tmr_q == '0);

  // R2: bank state must suit the command chosen by the arbiter
  p_act_closed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    act_i |-> !open_q);
  p_col_open_r2: assert property (@(posedge clk) disable iff (!rst_n)
    col_i |-> open_q);
  p_ref_closed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ref_i |-> !open_q);
  p_one_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({act_i, pre_i, col_i, ref_i}));
  // R3, R4: no command before the bank's delay has run out
  p_delay_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (act_i || pre_i || col_i || ref_i) |-> (tmr_q == '0));

endmodule

// File: rtl/sdr_ref_timer.sv
module sdr_ref_timer #(
  parameter int REF_PERIOD = 1040
) (
  input  logic clk,
  input  logic rst_n,
  input  logic done_i,
  output logic pend_o
);

  localparam int CW = $clog2(REF_PERIOD + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          pend_q, pend_d;
  logic          wrap;

  always_comb begin
    wrap   = (cnt_q == CW'(REF_PERIOD - 1));
    cnt_d  = wrap ? '0 : cnt_q + CW'(1);
    pend_d = wrap ? 1'b1 : (done_i ? 1'b0 : pend_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      pend_q <= pend_d;
    end
  end

  assign pend_o = pend_q;

  // R9: a refresh is only sent when one is owed, and then clears the request
  p_ref_owed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done_i |-> pend_q);
  p_ref_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && !wrap) |=> !pend_q);

endmodule

// File: rtl/sdr_rd_pipe.sv
module sdr_rd_pipe #(
  parameter int CAS_LAT = 2,
  parameter int TAG_W   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid_i,
  input  logic [TAG_W-1:0] in_tag_i,
  output logic             out_valid_o,
  output logic [TAG_W-1:0] out_tag_o
);

  logic [CAS_LAT-1:0] v_q, v_d;
  logic [CAS_LAT:0]   v_sh;
  logic [TAG_W-1:0]   t_q [CAS_LAT];

  always_comb begin
    v_sh = {v_q, in_valid_i};
    v_d  = v_sh[CAS_LAT-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_q <= '0;
    else        v_q <= v_d;
  end

  always_ff @(posedge clk) begin
    if (in_valid_i) t_q[0] <= in_tag_i;
    for (int s = 1; s < CAS_LAT; s++) begin
      if (v_q[s-1]) t_q[s] <= t_q[s-1];
    end
  end

  assign out_valid_o = v_q[CAS_LAT-1];
  assign out_tag_o   = t_q[CAS_LAT-1];

endmodule

// File: rtl/sdr_sched.sv
module sdr_sched
  import sdr_sched_pkg::*;
#(
  parameter int BANK_W     = 2,
  parameter int ROW_W      = 12,
  parameter int COL_W      = 8,
  parameter int DATA_W     = 16,
  parameter int TAG_W      = 4,
  parameter int QDEPTH     = 4,
  parameter int T_RCD      = 10,
  parameter int T_RP       = 3,
  parameter int T_RFC      = 8,
  parameter int CAS_LAT    = 2,
  parameter int REF_PERIOD = 1040
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          req_valid_i,
  output logic                          req_ready_o,
  input  logic                          req_we_i,
  input  logic [BANK_W+ROW_W+COL_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0]             req_wdata_i,
  input  logic [TAG_W-1:0]              req_tag_i,
  output logic [2:0]                    mem_cmd_o,
  output logic [BANK_W-1:0]             mem_bank_o,
  output logic [ROW_W-1:0]              mem_addr_o,
  output logic [DATA_W-1:0]             mem_wdata_o,
  input  logic [DATA_W-1:0]             mem_rdata_i,
  output logic                          rsp_valid_o,
  output logic [TAG_W-1:0]              rsp_tag_o,
  output logic [DATA_W-1:0]             rsp_data_o
);

  localparam int NBANK  = 1 << BANK_W;
  localparam int QIDX_W = (QDEPTH > 1) ? $clog2(QDEPTH) : 1;
  localparam int CNT_W  = $clog2(QDEPTH + 1);

  typedef struct packed {
    logic              we;
    logic [BANK_W-1:0] bank;
    logic [ROW_W-1:0]  row;
    logic [COL_W-1:0]  col;
    logic [DATA_W-1:0] wdata;
    logic [TAG_W-1:0]  tag;
  } req_t;

  // Request queue
  req_t              q_mem [QDEPTH];
  req_t              q_nxt [QDEPTH];
  req_t              in_req;
  logic [CNT_W-1:0]  count_q, count_d, wr_pos;
  logic              push;

  // Bank trackers
  logic [NBANK-1:0]  b_open, b_ready;
  logic [ROW_W-1:0]  b_row [NBANK];
  logic [NBANK-1:0]  b_act, b_pre, b_col;
  logic              ref_pend;

  // Arbiter decision
  sdr_cmd_e          iss_cmd;
  logic [BANK_W-1:0] iss_bank;
  logic [ROW_W-1:0]  iss_addr;
  logic [DATA_W-1:0] iss_wdata;
  logic [TAG_W-1:0]  iss_tag;
  logic              iss_pop, found;
  logic [QIDX_W-1:0] sel_idx;

  // Bus registers
  sdr_cmd_e          cmd_q;
  logic [BANK_W-1:0] bank_q;
  logic [ROW_W-1:0]  addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic [TAG_W-1:0]  tag_q;

  assign in_req = '{we: req_we_i,
                    bank: req_addr_i[BANK_W+ROW_W+COL_W-1 -: BANK_W],
                    row: req_addr_i[ROW_W+COL_W-1 -: ROW_W],
                    col: req_addr_i[COL_W-1:0],
                    wdata: req_wdata_i, tag: req_tag_i};

  assign req_ready_o = (count_q != CNT_W'(QDEPTH));
  assign push        = req_valid_i && req_ready_o;

  // Oldest eligible request first; a request waits behind any older one to its bank
  always_comb begin
    logic              blocked;
    logic [BANK_W-1:0] bk;
    found     = 1'b0;
    sel_idx   = '0;
    iss_cmd   = CMD_NOP;
    iss_bank  = '0;
    iss_addr  = '0;
    iss_wdata = '0;
    iss_tag   = '0;
    iss_pop   = 1'b0;
    for (int i = 0; i < QDEPTH; i++) begin
      bk      = q_mem[i].bank;
      blocked = 1'b0;
      for (int j = 0; j < QDEPTH; j++) begin
        if (j < i && q_mem[j].bank == bk) blocked = 1'b1;
      end
      if (!found && CNT_W'(i) < count_q && !blocked && b_ready[bk]) begin
        if (b_open[bk] && b_row[bk] == q_mem[i].row) begin
          found     = 1'b1;
          iss_cmd   = q_mem[i].we ? CMD_WR : CMD_RD;
          iss_addr  = ROW_W'(q_mem[i].col);
          iss_pop   = 1'b1;
        end else if (b_open[bk]) begin
          found     = 1'b1;
          iss_cmd   = CMD_PRE;
        end else if (!ref_pend) begin
          found     = 1'b1;
          iss_cmd   = CMD_ACT;
          iss_addr  = q_mem[i].row;
        end
        if (found) begin
          sel_idx   = QIDX_W'(i);
          iss_bank  = bk;
          iss_wdata = q_mem[i].wdata;
          iss_tag   = q_mem[i].tag;
        end
      end
    end
    if (!found && ref_pend) begin
      for (int b = 0; b < NBANK; b++) begin
        if (!found && b_open[b] && b_ready[b]) begin
          found    = 1'b1;
          iss_cmd  = CMD_PRE;
          iss_bank = BANK_W'(b);
        end
      end
      if (!found && b_open == '0 && (&b_ready)) begin
        found   = 1'b1;
        iss_cmd = CMD_REF;
      end
    end
  end

  // Queue next state: close the gap left by a pop, append at the tail
  always_comb begin
    int src;
    wr_pos  = count_q - CNT_W'(iss_pop);
    count_d = count_q + CNT_W'(push) - CNT_W'(iss_pop);
    for (int k = 0; k < QDEPTH; k++) begin
      src      = (k < QDEPTH - 1) ? k + 1 : k;
      q_nxt[k] = q_mem[k];
      if (iss_pop && k >= int'(sel_idx)) q_nxt[k] = q_mem[QIDX_W'(src)];
      if (push && CNT_W'(k) == wr_pos)   q_nxt[k] = in_req;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) count_q <= '0;
    else        count_q <= count_d;
  end

  always_ff @(posedge clk) begin
    if (push || iss_pop) q_mem <= q_nxt;
  end

  // Per-bank state
  for (genvar g = 0; g < NBANK; g++) begin : g_bank
    assign b_act[g] = (iss_cmd == CMD_ACT) && (iss_bank == BANK_W'(g));
    assign b_pre[g] = (iss_cmd == CMD_PRE) && (iss_bank == BANK_W'(g));
    assign b_col[g] = iss_pop && (iss_bank == BANK_W'(g));
    sdr_bank_track #(
      .ROW_W(ROW_W), .T_RCD(T_RCD), .T_RP(T_RP), .T_RFC(T_RFC)
    ) u_bank (
      .clk    (clk),
      .rst_n  (rst_n),
      .act_i  (b_act[g]),
      .pre_i  (b_pre[g]),
      .col_i  (b_col[g]),
      .ref_i  (iss_cmd == CMD_REF),
      .row_i  (iss_addr),
      .open_o (b_open[g]),
      .row_o  (b_row[g]),
      .ready_o(b_ready[g])
    );
  end

  sdr_ref_timer #(.REF_PERIOD(REF_PERIOD)) u_ref (
    .clk   (clk),
    .rst_n (rst_n),
    .done_i(iss_cmd == CMD_REF),
    .pend_o(ref_pend)
  );

  // Command bus registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmd_q <= CMD_NOP;
    else        cmd_q <= iss_cmd;
  end

  always_ff @(posedge clk) begin
    if (iss_cmd != CMD_NOP) begin
      bank_q  <= iss_bank;
      addr_q  <= iss_addr;
      wdata_q <= iss_wdata;
      tag_q   <= iss_tag;
    end
  end

  assign mem_cmd_o   = cmd_q;
  assign mem_bank_o  = bank_q;
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = wdata_q;

  sdr_rd_pipe #(.CAS_LAT(CAS_LAT), .TAG_W(TAG_W)) u_rd (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid_i (cmd_q == CMD_RD),
    .in_tag_i   (tag_q),
    .out_valid_o(rsp_valid_o),
    .out_tag_o  (rsp_tag_o)
  );

  assign rsp_data_o = mem_rdata_i;

  // R10: occupancy never passes the queue depth
  p_no_overflow_r10: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CNT_W'(QDEPTH));
  // R9: no row opens while a refresh is owed
  p_no_act_pending_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_cmd == CMD_ACT) |-> !ref_pend);
  // R2: refresh only with every tracker reporting closed
  p_ref_all_closed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_cmd == CMD_REF) |-> (b_open == '0));

endmodule

// File: tb/sim_sdr_sched.sv
module sim_sdr_sched;

  localparam int CLK_PERIOD = 10;
  localparam int CAS_LAT    = 3;
  localparam int REF_PERIOD = 300;
  localparam int T_RCD      = 10;
  localparam int T_RP       = 3;
  localparam int T_RFC      = 8;
  localparam int QDEPTH     = 4;
  localparam int NVEC       = 16;

  // {we, bank[1:0], row[11:0], col[3:0], wdata[15:0]}
  localparam logic [34:0] VEC [NVEC] = '{
    {1'b1, 2'd0, 12'd1, 4'd2,  16'h1111},
    {1'b0, 2'd0, 12'd1, 4'd2,  16'h0000},
    {1'b0, 2'd1, 12'd2, 4'd0,  16'h0000},
    {1'b0, 2'd2, 12'd3, 4'd5,  16'h0000},
    {1'b1, 2'd0, 12'd2, 4'd2,  16'h2222},
    {1'b0, 2'd0, 12'd1, 4'd2,  16'h0000},
    {1'b0, 2'd0, 12'd2, 4'd2,  16'h0000},
    {1'b1, 2'd3, 12'd0, 4'd15, 16'h3333},
    {1'b0, 2'd3, 12'd0, 4'd15, 16'h0000},
    {1'b0, 2'd1, 12'd2, 4'd1,  16'h0000},
    {1'b1, 2'd1, 12'd2, 4'd1,  16'h4444},
    {1'b0, 2'd1, 12'd2, 4'd1,  16'h0000},
    {1'b0, 2'd2, 12'd0, 4'd0,  16'h0000},
    {1'b0, 2'd3, 12'd1, 4'd7,  16'h0000},
    {1'b1, 2'd2, 12'd0, 4'd0,  16'h5555},
    {1'b0, 2'd2, 12'd0, 4'd0,  16'h0000}
  };

  logic        clk, rst_n;
  logic        req_valid, req_ready, req_we;
  logic [17:0] req_addr;
  logic [15:0] req_wdata, mem_wdata, mem_rdata, rsp_data;
  logic [3:0]  req_tag, rsp_tag;
  logic [2:0]  mem_cmd;
  logic [1:0]  mem_bank;
  logic [11:0] mem_addr;
  logic        rsp_valid;

  sdr_sched #(
    .BANK_W(2), .ROW_W(12), .COL_W(4), .DATA_W(16), .TAG_W(4),
    .QDEPTH(QDEPTH), .T_RCD(T_RCD), .T_RP(T_RP), .T_RFC(T_RFC),
    .CAS_LAT(CAS_LAT), .REF_PERIOD(REF_PERIOD)
  ) u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_we_i(req_we),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata), .req_tag_i(req_tag),
    .mem_cmd_o(mem_cmd), .mem_bank_o(mem_bank), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .rsp_valid_o(rsp_valid), .rsp_tag_o(rsp_tag), .rsp_data_o(rsp_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int checks, errors;
  bit done_flag;

  logic [15:0] ref_mem   [256];
  logic [15:0] model_mem [256];
  logic [15:0] exp_data  [16];
  bit          pend      [16];
  bit          is_order  [16];
  int          pend_cnt;
  logic [3:0]  tag_ctr;
  bit          saw_full;

  logic [3:0]  mopen;
  logic [11:0] mrow [4];
  int          act_cyc [4], rd_cyc [4], pre_cyc [4], act_b [4], pre_b [4];
  int          ref_cyc, ref_cnt, ref_max_gap, act_tot, cyc;
  bit          pv [CAS_LAT];
  logic [15:0] pd [CAS_LAT];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  function automatic logic [7:0] midx(input logic [1:0] b, input logic [11:0] r, input logic [3:0] c);
    return {b, r[1:0], c};
  endfunction

  task automatic send(input logic we, input logic [17:0] addr, input logic [15:0] d, input bit order_chk);
    logic [7:0] ix;
    ix        = midx(addr[17:16], addr[15:4], addr[3:0]);
    req_valid = 1'b1;
    req_we    = we;
    req_addr  = addr;
    req_wdata = d;
    req_tag   = tag_ctr;
    while (!req_ready) begin
      saw_full = 1'b1;
      @(negedge clk);
    end
    if (we) ref_mem[ix] = d;
    else begin
      exp_data[tag_ctr] = ref_mem[ix];
      pend[tag_ctr]     = 1'b1;
      is_order[tag_ctr] = order_chk;
      pend_cnt++;
    end
    tag_ctr = tag_ctr + 4'd1;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic drain();
    int n;
    n = 0;
    while (pend_cnt != 0 && n < 2000) begin
      @(negedge clk);
      n++;
    end
    repeat (4) @(negedge clk);
  endtask

  // Memory model and bus monitor
  always @(negedge clk) begin
    int b;
    logic [7:0] ix;
    cyc++;
    if (cyc > 30000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 30000);
      finish_run();
    end
    if (rst_n) begin
      if (rsp_valid) begin
        chk(pend[rsp_tag], "R8 response tag outstanding", 32'(rsp_tag), 32'(rsp_tag));
        if (is_order[rsp_tag])
          chk(rsp_data == exp_data[rsp_tag], "R6 read after write order", 32'(rsp_data), 32'(exp_data[rsp_tag]));
        else
          chk(rsp_data == exp_data[rsp_tag], "R8 read data at CAS latency", 32'(rsp_data), 32'(exp_data[rsp_tag]));
        if (pend[rsp_tag]) pend_cnt--;
        pend[rsp_tag] = 1'b0;
      end
      for (int k = CAS_LAT - 1; k > 0; k--) begin
        pv[k] = pv[k-1];
        pd[k] = pd[k-1];
      end
      pv[0] = 1'b0;
      pd[0] = 16'hDEAD;
      b = int'(mem_bank);
      case (mem_cmd)
        3'd0: ;
        3'd1: begin
          chk(!mopen[b], "R2 activate on closed bank", 32'(mopen), 32'(0));
          chk(cyc - pre_cyc[b] >= T_RP, "R4 precharge to activate", 32'(cyc - pre_cyc[b]), 32'(T_RP));
          chk(cyc - ref_cyc >= T_RFC, "R4 refresh to activate", 32'(cyc - ref_cyc), 32'(T_RFC));
          mopen[b]   = 1'b1;
          mrow[b]    = mem_addr;
          act_cyc[b] = cyc;
          act_b[b]++;
          act_tot++;
        end
        3'd2, 3'd3: begin
          chk(mopen[b], "R2 column command on open bank", 32'(mopen), 32'(1 << b));
          chk(cyc - act_cyc[b] >= T_RCD, "R3 activate to column", 32'(cyc - act_cyc[b]), 32'(T_RCD));
          ix = midx(mem_bank, mrow[b], mem_addr[3:0]);
          if (mem_cmd == 3'd3) model_mem[ix] = mem_wdata;
          else begin
            pv[0]     = 1'b1;
            pd[0]     = model_mem[ix];
            rd_cyc[b] = cyc;
          end
        end
        3'd4: begin
          mopen[b]   = 1'b0;
          pre_cyc[b] = cyc;
          pre_b[b]++;
        end
        3'd5: begin
          chk(mopen == 4'd0, "R2 refresh with all banks closed", 32'(mopen), 32'(0));
          if (ref_cnt > 0 && cyc - ref_cyc > ref_max_gap) ref_max_gap = cyc - ref_cyc;
          ref_cyc = cyc;
          ref_cnt++;
        end
        default: chk(1'b0, "R2 legal command code", 32'(mem_cmd), 32'(0));
      endcase
      mem_rdata = pv[CAS_LAT-1] ? pd[CAS_LAT-1] : 16'hDEAD;
    end
  end

  initial begin
    int r0, a0, p0, ap0;
    checks = 0; errors = 0; done_flag = 1'b0; cyc = 0;
    pend_cnt = 0; tag_ctr = '0; saw_full = 1'b0;
    mopen = '0; ref_cyc = -1000; ref_cnt = 0; ref_max_gap = 0; act_tot = 0;
    for (int i = 0; i < 256; i++) begin
      ref_mem[i]   = 16'hA000 ^ 16'(i);
      model_mem[i] = 16'hA000 ^ 16'(i);
    end
    for (int i = 0; i < 16; i++) begin
      pend[i] = 1'b0; is_order[i] = 1'b0; exp_data[i] = '0;
    end
    for (int i = 0; i < 4; i++) begin
      act_cyc[i] = -1000; rd_cyc[i] = -1000; pre_cyc[i] = -1000;
      act_b[i] = 0; pre_b[i] = 0; mrow[i] = '0;
    end
    for (int i = 0; i < CAS_LAT; i++) begin
      pv[i] = 1'b0; pd[i] = 16'hDEAD;
    end
    mem_rdata = 16'hDEAD;
    req_valid = 1'b0; req_we = 1'b0; req_addr = '0; req_wdata = '0; req_tag = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(mem_cmd == 3'd0, "R1 command idle in reset", 32'(mem_cmd), 32'(0));
    chk(!rsp_valid, "R1 no response in reset", 32'(rsp_valid), 32'(0));
    chk(req_ready, "R1 ready in reset", 32'(req_ready), 32'(1));
    rst_n = 1'b1;
    @(negedge clk);

    // Table-driven traffic mixing hits, misses and overlapping banks
    for (int v = 0; v < NVEC; v++) begin
      send(VEC[v][34], VEC[v][33:16], VEC[v][15:0], 1'b0);
    end
    drain();
    chk(pend_cnt == 0, "R8 every table read answered", 32'(pend_cnt), 32'(0));

    // Directed tests start just after a refresh, with all banks closed
    r0 = ref_cnt;
    while (ref_cnt == r0) @(negedge clk);

    // R7: second bank opens inside the first bank's row delay
    send(1'b0, {2'd0, 12'd3, 4'd0}, 16'h0, 1'b0);
    send(1'b0, {2'd1, 12'd3, 4'd0}, 16'h0, 1'b0);
    drain();
    chk(act_cyc[1] < rd_cyc[0], "R7 activate overlaps other bank", 32'(act_cyc[1]), 32'(rd_cyc[0]));

    // R5: two accesses to one new row need a single activate
    a0 = act_tot;
    send(1'b0, {2'd2, 12'd1, 4'd3}, 16'h0, 1'b0);
    send(1'b0, {2'd2, 12'd1, 4'd4}, 16'h0, 1'b0);
    drain();
    chk(act_tot - a0 == 1, "R5 row hit skips activate", 32'(act_tot - a0), 32'(1));

    // R5: a different row in an open bank needs precharge then activate
    p0 = pre_b[0]; ap0 = act_b[0];
    send(1'b0, {2'd0, 12'd0, 4'd0}, 16'h0, 1'b0);
    drain();
    chk(pre_b[0] - p0 == 1, "R5 row miss precharges", 32'(pre_b[0] - p0), 32'(1));
    chk(act_b[0] - ap0 == 1, "R5 row miss activates", 32'(act_b[0] - ap0), 32'(1));

    // R6: write then read of one address, same bank, queued back to back
    send(1'b1, {2'd1, 12'd0, 4'd9}, 16'h7777, 1'b0);
    send(1'b0, {2'd1, 12'd0, 4'd9}, 16'h0, 1'b1);
    drain();

    // R10: back-to-back misses to one bank fill the queue
    saw_full = 1'b0;
    for (int i = 0; i < 7; i++) begin
      send(1'b0, {2'd3, 12'(i % 4), 4'(i)}, 16'h0, 1'b0);
    end
    drain();
    chk(saw_full, "R10 ready drops when queue full", 32'(saw_full), 32'(1));
    chk(pend_cnt == 0, "R10 held requests all served", 32'(pend_cnt), 32'(0));

    // R9: idle time, then refresh spacing
    repeat (3 * REF_PERIOD) @(negedge clk);
    chk(ref_cnt >= cyc / REF_PERIOD - 1, "R9 refresh count", 32'(ref_cnt), 32'(cyc / REF_PERIOD - 1));
    chk(ref_max_gap <= REF_PERIOD + 40, "R9 refresh spacing", 32'(ref_max_gap), 32'(REF_PERIOD + 40));
    finish_run();
  end

endmodule